// File: doc/BRIEF.md
# Multiply-Accumulate Peripheral Unit

This block is a register-mapped 16x16 multiplier that sits beside a small processor. Software programs a control word and writes the two operands in any order, at any speed. The unit then runs one of these operations into a 32-bit accumulator:
- a plain product,
- a square of operand A,
- a multiply-accumulate,
- a multiply-subtract.

The result is read back in two 16-bit halves. A carry or borrow out of the top accumulator bit is reported on a flag. The accumulator is not widened.

Register writes arrive on a valid/ready port. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays low for the whole calculation. While it is low, the master holds the same address and data until the write is taken, and it can never lose or reorder a write.

Reads are plain and combinational. `busy`, `result_valid` and `overflow` are level status pins.

Register addresses:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | operand A | read/write |
| 2 | operand B | read/write |
| 3 | accumulator high half | read/write |
| 4 | accumulator low half | read/write |
| 5 | result high half | read-only |
| 6 | result low half | read-only |
| 7 | reads zero | read-only |

Control bits:

| Bit | Meaning when 1 |
|---|---|
| 0 | two-operand mode |
| 1 | signed operands |
| 2 | accumulate |
| 3 | subtract (only together with bit 2) |
| 4 | square |
| 5 | clear (an action, not stored) |

Top module: `mac_unit`

## Requirements
- R1: After reset, every register reads zero. `busy`, `result_valid` and `overflow` are low, and `wr_ready` is high.
- R2: Control 21h selects an unsigned two-operand product and clears the accumulator. The calculation starts on whichever operand write comes second, in either order. Result = A*B.
- R3: `overflow` is updated only when an operation completes, or by a clear. It is set when an accumulate carries out of bit 31, or when a subtract borrows out of bit 31. Otherwise it is cleared.
- R4: With control bit 4 set, a write to operand A starts A*A. The value held in operand B has no effect.
- R5: `busy` goes high after the edge that accepts the starting write. It stays high for exactly LATENCY cycles. `result_valid` drops at the start and rises when `busy` falls.
- R6: `wr_ready` is low whenever `busy` is high. A write offered during that time takes effect only after `busy` falls.
- R7: With control bit 1 set, both operands are two's complement. The product is sign-extended to 32 bits.
- R8: Control bit 2 adds the product to the accumulator. Bits 2 and 3 together subtract the product from the accumulator. Without bit 2, the accumulator is replaced by the product.
- R9: With control bits 0 and 4 both clear, a write to operand A starts A times the stored operand B. A write to operand B alone starts nothing.
- R10: Address 5 returns result bits [31:16] and address 6 returns bits [15:0]. Addresses 3 and 4 write and read the two accumulator halves.
- R11: A control write with bit 5 set clears the accumulator, the result, `overflow` and `result_valid`. Bit 5 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| busy | output | 1 | Calculation in progress |
| result_valid | output | 1 | Result registers hold a finished result |
| overflow | output | 1 | Carry or borrow out of bit 31 on the last operation |

## Verification
On every cycle, the assertions check these properties:
- `wr_ready` is never high while `busy` is high.
- Every busy interval lasts exactly LATENCY cycles and ends with `result_valid` set.
- `overflow` moves only at completion or on a clear.
- A clear leaves the flags low.

The arithmetic itself needs the bench scenarios:
- signed versus unsigned products;
- squares that ignore operand B;
- either order of operand entry;
- accumulate and subtract wrapping through bit 31;
- a write held off by back-pressure and landing after the calculation.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OPA   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_OPB   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ACCH  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACCL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RESH  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_RESL  = 3'd6;

  localparam int CLR_BIT = 5;
  localparam int CTRL_W  = 5;

  typedef struct packed {
    logic square;
    logic sub;
    logic accum;
    logic signed_op;
    logic two_op;
  } mac_ctrl_t;
endpackage

// File: rtl/mac_regs.sv
module mac_regs
  import mac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  output mac_ctrl_t            ctrl_q,
  output logic [WIDTH-1:0]     op_a_q,
  output logic [WIDTH-1:0]     op_b_q,
  output logic                 start_now,
  output logic                 start_q,
  output logic                 clear_now
);
  logic have_a_q, have_b_q;
  logic pair_mode;
  logic wr_ctrl, wr_a, wr_b;

  assign pair_mode = ctrl_q.two_op && !ctrl_q.square;
  assign wr_ctrl   = wr_fire && (wr_addr == ADR_CTRL);
  assign wr_a      = wr_fire && (wr_addr == ADR_OPA);
  assign wr_b      = wr_fire && (wr_addr == ADR_OPB);
  assign clear_now = wr_ctrl && wr_data[CLR_BIT];

  always_comb begin
    start_now = 1'b0;
    if (wr_a) start_now = pair_mode ? have_b_q : 1'b1;
    if (wr_b) start_now = pair_mode && have_a_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      op_a_q   <= '0;
      op_b_q   <= '0;
      have_a_q <= 1'b0;
      have_b_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= start_now;
      if (wr_ctrl) begin
        ctrl_q   <= mac_ctrl_t'(wr_data[CTRL_W-1:0]);
        have_a_q <= 1'b0;
        have_b_q <= 1'b0;
      end
      if (wr_a) op_a_q <= wr_data;
      if (wr_b) op_b_q <= wr_data;
      if (start_now) begin
        have_a_q <= 1'b0;
        have_b_q <= 1'b0;
      end else begin
        if (wr_a) have_a_q <= 1'b1;
        if (wr_b) have_b_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int WIDTH = 16,
  localparam int PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             signed_op,
  output logic [PW-1:0]    prod
);
  logic signed [PW-1:0] s_a, s_b, s_prod;
  logic [PW-1:0]        u_prod;

  assign s_a    = PW'($signed(a));
  assign s_b    = PW'($signed(b));
  assign s_prod = s_a * s_b;
  assign u_prod = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
  assign prod   = signed_op ? s_prod : u_prod;
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [DW-1:0] out_data,
  output logic          any_vld
);
  logic [STAGES-1:0] vld_q;
  logic [DW-1:0]     dat_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
          end else begin
            vld_q[0] <= in_vld;
            if (in_vld) dat_q[0] <= in_data;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            vld_q[s] <= 1'b0;
            dat_q[s] <= '0;
          end else begin
            vld_q[s] <= vld_q[s-1];
            if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign out_vld  = vld_q[STAGES-1];
  assign out_data = dat_q[STAGES-1];
  assign any_vld  = |vld_q;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int PW = 2 * WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_now,
  input  logic              start_now,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              done,
  input  logic [PW-1:0]     prod,
  input  mac_ctrl_t         ctrl,
  output logic [PW-1:0]     acc_q,
  output logic [PW-1:0]     res_q,
  output logic              ovf_q,
  output logic              valid_q
);
  logic [PW:0] add_w, sub_w;
  logic [PW:0] next_w;

  assign add_w = {1'b0, acc_q} + {1'b0, prod};
  assign sub_w = {1'b0, acc_q} - {1'b0, prod};

  always_comb begin
    if (!ctrl.accum)   next_w = {1'b0, prod};
    else if (ctrl.sub) next_w = sub_w;
    else               next_w = add_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_now) begin
      acc_q   <= '0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (start_now) valid_q <= 1'b0;
      if (wr_hi) acc_q[PW-1:WIDTH] <= wr_data;
      if (wr_lo) acc_q[WIDTH-1:0]  <= wr_data;
      if (done) begin
        acc_q   <= next_w[PW-1:0];
        res_q   <= next_w[PW-1:0];
        ovf_q   <= next_w[PW];
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [2:0]        wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [2:0]        rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              busy,
  output logic              result_valid,
  output logic              overflow
);
  localparam int PW     = 2 * WIDTH;
  localparam int STAGES = (LATENCY < 2) ? 1 : LATENCY - 1;

  mac_ctrl_t         ctrl;
  logic [WIDTH-1:0]  op_a, op_b, b_eff;
  logic              start_now, start_q, clear_now, wr_fire;
  logic [PW-1:0]     prod, pipe_prod, acc, res;
  logic              pipe_done, pipe_any;

  assign wr_fire  = wr_valid && wr_ready;
  assign busy     = start_q || pipe_any;
  assign wr_ready = !busy;

  mac_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl), .op_a_q(op_a), .op_b_q(op_b),
    .start_now(start_now), .start_q(start_q), .clear_now(clear_now)
  );

  assign b_eff = ctrl.square ? op_a : op_b;

  mac_mult #(.WIDTH(WIDTH)) u_mult (
    .a(op_a), .b(b_eff), .signed_op(ctrl.signed_op), .prod(prod)
  );

  mac_pipe #(.DW(PW), .STAGES(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(start_q), .in_data(prod),
    .out_vld(pipe_done), .out_data(pipe_prod), .any_vld(pipe_any)
  );

  mac_accum #(.WIDTH(WIDTH)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear_now(clear_now), .start_now(start_now),
    .wr_hi(wr_fire && wr_addr == ADR_ACCH),
    .wr_lo(wr_fire && wr_addr == ADR_ACCL),
    .wr_data(wr_data), .done(pipe_done), .prod(pipe_prod), .ctrl(ctrl),
    .acc_q(acc), .res_q(res), .ovf_q(overflow), .valid_q(result_valid)
  );

  always_comb begin
    case (rd_addr)
      ADR_CTRL: rd_data = {{(WIDTH-CTRL_W){1'b0}}, ctrl};
      ADR_OPA:  rd_data = op_a;
      ADR_OPB:  rd_data = op_b;
      ADR_ACCH: rd_data = acc[PW-1:WIDTH];
      ADR_ACCL: rd_data = acc[WIDTH-1:0];
      ADR_RESH: rd_data = res[PW-1:WIDTH];
      ADR_RESL: rd_data = res[WIDTH-1:0];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [2:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             busy,
  input logic             result_valid,
  input logic             overflow
);
  logic [31:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= '0;
    else        busy_len <= busy ? busy_len + 32'd1 : 32'd0;
  end

  assert_ready_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 32'(LATENCY)));

  assert_done_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || result_valid));

  assert_start_drops_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !result_valid);

  assert_ovf_moves_at_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(overflow) |-> ($past(busy) ||
      $past(wr_valid && wr_ready && wr_addr == 3'd0 && wr_data[5])));

  assert_clear_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == 3'd0 && wr_data[5]) |=>
      (!overflow && !result_valid && !busy));
endmodule

bind mac_unit mac_unit_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
  .result_valid(result_valid), .overflow(overflow)
);

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic        wr_ready, busy, result_valid, overflow;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit hold_rd = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_unit #(.WIDTH(16), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .result_valid(result_valid), .overflow(overflow)
  );

  // behavioural reference model
  logic [4:0]  m_ctrl;
  logic [15:0] m_a, m_b;
  logic [31:0] m_acc, m_res;
  bit m_ovf, m_valid, m_ha, m_hb;
  int m_cnt;

  task automatic m_finish();
    longint pa, pb;
    logic [31:0] p;
    logic [32:0] s;
    logic [15:0] bb;
    bb = m_ctrl[4] ? m_a : m_b;
    if (m_ctrl[1]) begin
      pa = longint'($signed(m_a));
      pb = longint'($signed(bb));
    end else begin
      pa = longint'(m_a);
      pb = longint'(bb);
    end
    p = 32'(pa * pb);
    if (!m_ctrl[2])     s = {1'b0, p};
    else if (m_ctrl[3]) s = {1'b0, m_acc} - {1'b0, p};
    else                s = {1'b0, m_acc} + {1'b0, p};
    m_acc = s[31:0];
    m_res = s[31:0];
    m_ovf = s[32];
    m_valid = 1'b1;
  endtask

  task automatic m_start();
    m_cnt = LAT;
    m_valid = 1'b0;
    m_ha = 1'b0;
    m_hb = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_a = '0; m_b = '0; m_acc = '0; m_res = '0;
      m_ovf = 0; m_valid = 0; m_ha = 0; m_hb = 0; m_cnt = 0;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) m_finish();
    end else if (wr_valid) begin
      case (wr_addr)
        3'd0: begin
          m_ctrl = wr_data[4:0]; m_ha = 0; m_hb = 0;
          if (wr_data[5]) begin
            m_acc = '0; m_res = '0; m_ovf = 0; m_valid = 0;
          end
        end
        3'd1: begin
          m_a = wr_data;
          if (m_ctrl[4] || !m_ctrl[0] || m_hb) m_start();
          else m_ha = 1;
        end
        3'd2: begin
          m_b = wr_data;
          if (m_ctrl[0] && !m_ctrl[4]) begin
            if (m_ha) m_start(); else m_hb = 1;
          end
        end
        3'd3: m_acc[31:16] = wr_data;
        3'd4: m_acc[15:0]  = wr_data;
        default: ;
      endcase
    end
  end

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {11'd0, m_ctrl};
      3'd1: return m_a;
      3'd2: return m_b;
      3'd3: return m_acc[31:16];
      3'd4: return m_acc[15:0];
      3'd5: return m_res[31:16];
      3'd6: return m_res[15:0];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5", "busy", 32'(busy), 32'(m_cnt > 0));
      check("R6", "wr_ready", 32'(wr_ready), 32'(m_cnt == 0));
      check("R5", "result_valid", 32'(result_valid), 32'(m_valid));
      check("R3", "overflow", 32'(overflow), 32'(m_ovf));
      check("R10", "rd_data", 32'(rd_data), 32'(m_read(rd_addr)));
      if (!hold_rd) rd_addr = rd_addr + 3'd1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(posedge clk);
    #2 hold_rd = 1'b1; rd_addr = a;
    #1 check(req, "register read", 32'(rd_data), 32'(exp));
    #1 hold_rd = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", 32'(busy), 0);
    check("R1", "wr_ready", 32'(wr_ready), 1);
    check("R1", "valid/ovf", {30'd0, result_valid, overflow}, 0);
    rd_chk(3'd5, 16'h0, "R1");
    rd_chk(3'd2, 16'h0, "R1");

    // R2 A then B
    wr(3'd0, 16'h0021); wr(3'd1, 16'h1234);
    check("R2", "no start after first operand", 32'(busy), 0);
    wr(3'd2, 16'h5678); wait_idle();
    rd_chk(3'd5, 16'h0626, "R2"); rd_chk(3'd6, 16'h0060, "R2");
    rd_chk(3'd0, 16'h0001, "R11");
    // R2 B then A
    wr(3'd0, 16'h0021); wr(3'd2, 16'h5678); wr(3'd1, 16'h1234); wait_idle();
    rd_chk(3'd5, 16'h0626, "R2"); rd_chk(3'd6, 16'h0060, "R2");

    // R9 one-operand mode, R6 back-pressure, R5 latency
    wr(3'd0, 16'h0020); wr(3'd2, 16'h0002);
    check("R9", "operand B alone starts nothing", 32'(busy), 0);
    wr(3'd1, 16'h0003);
    n = 0;
    while (busy) begin
      check("R6", "wr_ready low while busy", 32'(wr_ready), 0);
      n++; @(negedge clk);
    end
    check("R5", "busy cycles", 32'(n), 32'(LAT));
    rd_chk(3'd6, 16'h0006, "R9");
    wr(3'd1, 16'h0004);
    wr(3'd2, 16'h0009);
    rd_chk(3'd2, 16'h0009, "R6");
    rd_chk(3'd6, 16'h0008, "R6");

    // R7 signed
    wr(3'd0, 16'h0023); wr(3'd1, 16'hFFFE); wr(3'd2, 16'h0003); wait_idle();
    rd_chk(3'd5, 16'hFFFF, "R7"); rd_chk(3'd6, 16'hFFFA, "R7");
    wr(3'd0, 16'h0021); wr(3'd1, 16'hFFFE); wr(3'd2, 16'h0003); wait_idle();
    rd_chk(3'd5, 16'h0002, "R7"); rd_chk(3'd6, 16'hFFFA, "R7");

    // R4 square ignores B
    wr(3'd0, 16'h0030); wr(3'd2, 16'h7777); wr(3'd1, 16'h0100); wait_idle();
    rd_chk(3'd5, 16'h0001, "R4"); rd_chk(3'd6, 16'h0000, "R4");

    // R8/R3 accumulate overflow
    wr(3'd0, 16'h0004); wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF);
    rd_chk(3'd3, 16'hFFFF, "R10");
    wr(3'd2, 16'h0001); wr(3'd1, 16'h0001); wait_idle();
    check("R3", "carry sets overflow", 32'(overflow), 1);
    rd_chk(3'd6, 16'h0000, "R8");
    // subtract with borrow
    wr(3'd0, 16'h000C); wr(3'd2, 16'h0002); wr(3'd1, 16'h0003); wait_idle();
    check("R3", "borrow sets overflow", 32'(overflow), 1);
    rd_chk(3'd6, 16'hFFFA, "R8");
    wr(3'd1, 16'h0001); wait_idle();
    check("R3", "no borrow clears overflow", 32'(overflow), 0);
    rd_chk(3'd5, 16'hFFFF, "R8"); rd_chk(3'd6, 16'hFFF8, "R8");
    // accumulate two-op after clear
    wr(3'd0, 16'h0025); wr(3'd1, 16'h000A); wr(3'd2, 16'h000A); wait_idle();
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0001); wait_idle();
    rd_chk(3'd6, 16'h0065, "R8");

    // R11 clear
    wr(3'd0, 16'h0020);
    check("R11", "valid cleared", 32'(result_valid), 0);
    rd_chk(3'd6, 16'h0000, "R11"); rd_chk(3'd4, 16'h0000, "R11");
    rd_chk(3'd0, 16'h0000, "R11");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule